// File: doc/BRIEF.md
# Read-Triggered SPI Master

This block is a single-chip-select SPI master with a small register bus of 16-bit registers. Software loads the transmit buffer and then reads the receive buffer. In the default initiation mode that read is what launches the next serial word. The read returns the word received last, and the new word shifts out the current transmit-buffer contents. When a word completes, the received data is copied to the receive buffer and a level interrupt is raised.

Draining the final word of a burst needs care, because a plain receive-buffer read would start one more word. Software has two options. It can read the shadow address, which returns the same data with no side effect. Or it can clear the enable bit and then read the receive buffer, which clears the interrupt without launching anything. While the block is disabled, its SCLK, MOSI and chip-select output enables are low.

Word size is 8 or 16 bits, bit order is MSB- or LSB-first, and all four clock polarity and phase combinations are supported. Each word runs on the settings captured when that word starts.

Top module: `spi_rdtrig_master`

## Requirements
- R1: After reset, control reads 0x000B, baud reads BAUD_INIT (default 4), status reads 0, cs_n_o is 1, the three output enables are 1, sclk_o is 0 and irq_o is 0. Register addresses are: 0 control, 1 baud, 2 transmit, 3 receive, 4 shadow, 5 status. Status bit 0 is busy and bit 1 is receive-full. Control bits are: 0 enable, 1 master, 2 CPOL, 3 CPHA, 4 LSB-first, 5 size, 7:6 initiation mode.
- R2: In mode 00, with enable and master set and no word in progress, a read of address 3 starts a word that shifts out the transmit buffer. The word is active in the next cycle, with busy set and cs_n_o low. A read of address 3 while a word is in progress starts nothing, and neither does one made with the master bit clear.
- R3: A read of address 4 returns the same word as address 3. It does not start a word, and it leaves receive-full and irq_o set.
- R4: With enable clear, sclk_oe, mosi_oe and cs_oe are 0. A read of address 3 then clears receive-full and irq_o and starts nothing.
- R5: The SCLK half period is H = max(baud, 2) system clocks. The first SCLK edge comes H clocks after cs_n_o falls, and the second edge comes H clocks after the first.
- R6: cs_n_o stays low for (2N+1)·H clocks per word, where N is the word length. That is half a bit before the first edge, the 2N edges, and half a bit after the last edge.
- R7: With size set, 16 bits are shifted. With size clear, only the low byte of the transmit buffer is shifted, and the received byte is zero-extended to 16 bits.
- R8: With LSB-first set, bit 0 goes out and is received first. Otherwise the top bit of the word goes first.
- R9: SCLK idles at CPOL. With CPHA 0, data is sampled on odd-numbered edges and changes on even ones. With CPHA 1, data changes on odd edges and is sampled on even ones. Each word has exactly 2N edges.
- R10: Writes to control during a word do not alter that word's size, order or phase.
- R11: irq_o is high exactly while receive-full is set. It rises in the cycle busy falls, and it is cleared by a read of address 3.
- R12: In mode 01, a write to address 2 starts a word carrying the written value, and a read of address 3 starts nothing. In modes 10 and 11, neither access starts a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of bus_rd |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| cs_n_o | output | 1 | Active-low chip select |
| cs_oe | output | 1 | Chip select output enable |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Word-complete interrupt, level high |

## Verification
The properties assume that bus_rd and bus_wr are never asserted together. They also assume the baud register is written only while no word is in progress, because the edge-spacing check reads the live register value. The stimulus respects both assumptions. Each bus access is a single strobe followed by an idle cycle. Baud, transmit data and control are written before the triggering read, and the only control write made during a word keeps the enable, master and CPOL bits unchanged.

// File: rtl/spi_rdtrig_master.sv
module spi_rdtrig_master #(
  parameter logic [15:0] BAUD_INIT = 16'd4,
  parameter logic [15:0] CTRL_INIT = 16'h000B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk_o,
  output logic        sclk_oe,
  output logic        mosi_o,
  output logic        mosi_oe,
  output logic        cs_n_o,
  output logic        cs_oe,
  input  logic        miso_i,
  output logic        irq_o
);

  localparam logic [2:0]  A_CTRL = 3'd0;
  localparam logic [2:0]  A_BAUD = 3'd1;
  localparam logic [2:0]  A_TX   = 3'd2;
  localparam logic [2:0]  A_RX   = 3'd3;
  localparam logic [2:0]  A_SHD  = 3'd4;
  localparam logic [2:0]  A_STAT = 3'd5;
  localparam logic [15:0] MIN_HALF = 16'd2;

  logic [15:0] ctrl, baud, txbuf, rxbuf, tx_lat, rx_sh, half_len, cnt;
  logic        rx_full, busy, sclk_q, mosi_q, w_cpha, w_lsb, w_size;
  logic [5:0]  half;
  logic [4:0]  txi, rxi;

  wire        en    = ctrl[0];
  wire        mstr  = ctrl[1];
  wire [1:0]  imode = ctrl[7:6];
  wire        rx_rd = bus_rd && (bus_addr == A_RX);
  wire        tx_wr = bus_wr && (bus_addr == A_TX);
  wire        start = en && mstr && !busy &&
                      ((imode == 2'b00 && rx_rd) || (imode == 2'b01 && tx_wr));
  wire [15:0] load_val  = tx_wr ? bus_wdata : txbuf;
  wire [15:0] eff       = (baud < MIN_HALF) ? MIN_HALF : baud;
  wire [4:0]  nbits     = w_size ? 5'd16 : 5'd8;
  wire [5:0]  last_edge = {nbits, 1'b0};
  wire        tick      = (cnt == half_len - 16'd1);
  wire        lead      = ~half[0];
  wire        smp       = w_cpha ? ~lead : lead;
  wire [4:0]  txn       = txi + 5'd1;
  wire        drv       = ~smp && (~w_cpha || half != 6'd0) && (txn < nbits);

  function automatic logic [3:0] bitpos(input logic lsb, input logic sz, input logic [4:0] i);
    bitpos = lsb ? i[3:0] : ((sz ? 4'd15 : 4'd7) - i[3:0]);
  endfunction

  always_comb begin
    case (bus_addr)
      A_CTRL:        bus_rdata = ctrl;
      A_BAUD:        bus_rdata = baud;
      A_TX:          bus_rdata = txbuf;
      A_RX, A_SHD:   bus_rdata = rxbuf;
      A_STAT:        bus_rdata = {14'd0, rx_full, busy};
      default:       bus_rdata = 16'd0;
    endcase
  end

  assign sclk_o  = busy ? sclk_q : ctrl[2];
  assign mosi_o  = mosi_q;
  assign cs_n_o  = ~busy;
  assign sclk_oe = en;
  assign mosi_oe = en;
  assign cs_oe   = en;
  assign irq_o   = rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= CTRL_INIT;
      baud     <= BAUD_INIT;
      txbuf    <= '0;
      rxbuf    <= '0;
      tx_lat   <= '0;
      rx_sh    <= '0;
      half_len <= MIN_HALF;
      cnt      <= '0;
      half     <= '0;
      txi      <= '0;
      rxi      <= '0;
      rx_full  <= 1'b0;
      busy     <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      w_cpha   <= 1'b0;
      w_lsb    <= 1'b0;
      w_size   <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL:  ctrl  <= bus_wdata;
          A_BAUD:  baud  <= bus_wdata;
          A_TX:    txbuf <= bus_wdata;
          default: ;
        endcase
      end
      if (rx_rd) rx_full <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
      end else if (start) begin
        busy     <= 1'b1;
        half_len <= eff;
        w_cpha   <= ctrl[3];
        w_lsb    <= ctrl[4];
        w_size   <= ctrl[5];
        cnt      <= '0;
        half     <= '0;
        txi      <= '0;
        rxi      <= '0;
        rx_sh    <= '0;
        tx_lat   <= load_val;
        sclk_q   <= ctrl[2];
        mosi_q   <= load_val[bitpos(ctrl[4], ctrl[5], 5'd0)];
      end else if (busy) begin
        if (!tick) begin
          cnt <= cnt + 16'd1;
        end else begin
          cnt  <= '0;
          half <= half + 6'd1;
          if (half < last_edge) begin
            sclk_q <= ~sclk_q;
            if (smp) begin
              rx_sh[bitpos(w_lsb, w_size, rxi)] <= miso_i;
              rxi <= rxi + 5'd1;
            end
            if (drv) begin
              mosi_q <= tx_lat[bitpos(w_lsb, w_size, txn)];
              txi    <= txn;
            end
          end else begin
            busy    <= 1'b0;
            rxbuf   <= rx_sh;
            rx_full <= 1'b1;
          end
        end
      end
    end
  end

endmodule

module spi_rdtrig_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [2:0]  bus_addr,
  input logic        en_i,
  input logic        mstr_i,
  input logic [1:0]  imode_i,
  input logic [15:0] baud_i,
  input logic        busy_i,
  input logic        cs_n_o,
  input logic        sclk_o,
  input logic        irq_o
);
  logic [16:0] gap;
  logic        sclk_d;
  wire  [16:0] exp_half = (baud_i < 16'd2) ? 17'd2 : {1'b0, baud_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap    <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_n_o)               gap <= '0;
      else if (sclk_o != sclk_d) gap <= 17'd1;
      else                       gap <= gap + 17'd1;
    end
  end

  // R2
  rd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3 && en_i && mstr_i && imode_i == 2'b00 && !busy_i)
      |=> (busy_i && !cs_n_o));

  // R3
  shadow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4 && !busy_i) |=> !busy_i);

  // R3
  shadow_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4 && irq_o) |=> irq_o);

  // R4
  off_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && bus_rd && bus_addr == 3'd3) |=> (!irq_o && !busy_i));

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(busy_i) && !busy_i));

  // R5
  half_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && sclk_o != sclk_d) |-> (gap == exp_half));
endmodule

bind spi_rdtrig_master spi_rdtrig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .en_i(ctrl[0]), .mstr_i(ctrl[1]), .imode_i(ctrl[7:6]), .baud_i(baud),
  .busy_i(busy), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .irq_o(irq_o)
);

// File: tb/sim_spi_rdtrig_master.sv
module sim_spi_rdtrig_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sclk_o, sclk_oe, mosi_o, mosi_oe, cs_n_o, cs_oe, irq_o;
  logic miso_i = 1'b0;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  spi_rdtrig_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .cs_n_o(cs_n_o), .cs_oe(cs_oe),
    .miso_i(miso_i), .irq_o(irq_o)
  );

  // slave model and frame monitor
  logic b_cpha = 0, b_lsb = 0, b_size = 0;
  logic [15:0] s_word = '0, cap_word = '0;
  int ek = 0, capn = 0, lowcnt = 0, e1 = 0, e2 = 0;
  logic prev_sclk = 0, prev_cs = 1;

  function automatic int bp(int i);
    int n = b_size ? 16 : 8;
    return b_lsb ? i : n - 1 - i;
  endfunction

  always @(negedge clk) begin
    int n;
    n = b_size ? 16 : 8;
    if (prev_cs && !cs_n_o) begin
      ek = 0; capn = 0; cap_word = '0; lowcnt = 0; e1 = 0; e2 = 0;
      miso_i = s_word[bp(0)];
    end
    if (!cs_n_o) begin
      lowcnt++;
      if (sclk_o != prev_sclk) begin
        ek++;
        if (ek == 1) e1 = lowcnt;
        if (ek == 2) e2 = lowcnt;
        if (b_cpha ? (ek % 2 == 0) : (ek % 2 == 1)) begin
          if (capn < n) cap_word[bp(capn)] = mosi_o;
          capn++;
        end else begin
          int idx;
          idx = b_cpha ? (ek - 1) / 2 : ek / 2;
          if (idx < n) miso_i = s_word[bp(idx)];
        end
      end
    end
    prev_sclk = sclk_o;
    prev_cs = cs_n_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] cfg(input logic cpol, cpha, lsb, size);
    return {8'h00, 2'b00, size, lsb, cpha, cpol, 2'b11};
  endfunction

  task automatic start_word(input logic cpol, cpha, lsb, size,
                            input logic [15:0] bv, tx, sw);
    logic [15:0] d;
    b_cpha = cpha; b_lsb = lsb; b_size = size; s_word = sw;
    wr(3'd0, cfg(cpol, cpha, lsb, size));
    wr(3'd1, bv);
    wr(3'd2, tx);
    rd(3'd3, d);
  endtask

  task automatic finish_word(input logic [15:0] bv, tx, sw);
    logic [15:0] d, mask;
    int n, h;
    n = b_size ? 16 : 8;
    h = (bv < 2) ? 2 : bv;
    mask = b_size ? 16'hFFFF : 16'h00FF;
    do rd(3'd5, d); while (d[0]);
    @(negedge clk);
    chk("R6 cs low length", lowcnt, (2 * n + 1) * h);
    chk("R5 first edge", e1, h + 1);
    chk("R5 second edge", e2, 2 * h + 1);
    chk("R9 edge count", ek, 2 * n);
    chk("R7 R8 mosi word", cap_word, tx & mask);
    chk("R11 irq after word", irq_o, 1);
    rd(3'd4, d);
    chk("R3 R7 R8 shadow data", d, sw & mask);
    chk("R3 irq kept", irq_o, 1);
    rd(3'd5, d);
    chk("R3 status after shadow", d, 16'h0002);
    wr(3'd0, 16'h0000);
    chk("R4 oe off", {sclk_oe, mosi_oe, cs_oe}, 0);
    rd(3'd3, d);
    chk("R4 rx data", d, sw & mask);
    chk("R4 R11 irq cleared", irq_o, 0);
    rd(3'd5, d);
    chk("R4 no start", d, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d, tx, sw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(3'd0, d); chk("R1 ctrl", d, 16'h000B);
    rd(3'd1, d); chk("R1 baud", d, 16'd4);
    rd(3'd5, d); chk("R1 status", d, 0);
    chk("R1 pins", {cs_n_o, sclk_oe, mosi_oe, cs_oe, sclk_o, irq_o}, 6'b111100);

    // R5 R6 R7 R8 R9 sweep over modes and half periods
    for (int m = 0; m < 16; m++) begin
      for (int b = 0; b < 4; b++) begin
        logic [15:0] bv;
        bv = (b == 3) ? 16'd5 : 16'(b + 1) - 16'(b == 0);
        tx = 16'hA5C3 ^ 16'(m * 16'h1357) ^ 16'(b * 16'h0421);
        sw = 16'h3C69 + 16'(m * 16'h00F1) + 16'(b * 16'h1103);
        start_word(m[0], m[1], m[2], m[3], bv, tx, sw);
        finish_word(bv, tx, sw);
      end
    end

    // R10 and R2: control write and extra rx read during a word
    tx = 16'h8137; sw = 16'h4E2D;
    start_word(1'b0, 1'b0, 1'b0, 1'b1, 16'd2, tx, sw);
    wr(3'd0, cfg(1'b0, 1'b1, 1'b1, 1'b0));
    rd(3'd3, d);
    finish_word(16'd2, tx, sw);

    // R2: master bit clear does not start
    wr(3'd0, 16'h0001);
    rd(3'd3, d);
    rd(3'd5, d); chk("R2 no start without master", d, 0);
    chk("R2 cs idle", cs_n_o, 1);

    // R12: mode 01 uses transmit write
    b_cpha = 0; b_lsb = 0; b_size = 0; s_word = 16'h00B4;
    wr(3'd0, 16'h0043);
    wr(3'd1, 16'd2);
    rd(3'd3, d);
    rd(3'd5, d); chk("R12 rx read ignored in mode 01", d, 0);
    wr(3'd2, 16'h005A);
    finish_word(16'd2, 16'h005A, 16'h00B4);

    // R12: mode 10 starts nothing
    wr(3'd0, 16'h0083);
    rd(3'd3, d);
    wr(3'd2, 16'h1234);
    rd(3'd5, d); chk("R12 mode 10 idle", d, 0);
    chk("R12 mode 10 cs", cs_n_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule